// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a recovered line data stream, one sample per bit clock, and decides whether the channel has lost its signal. The stream arrives as two rails, one for positive marks and one for negative marks. A mark on either rail in a bit period counts as a pulse. A digital detector declares a defect after a long unbroken run of pulse-free bit periods. It withdraws that defect only when a fixed-length measurement window shows enough pulse density. Declaring and clearing therefore use two different criteria.

An amplitude-based loss indication comes from an analog comparator outside this block. It is brought into the bit clock domain through a synchronizer and ORed with the digital verdict to form the channel loss state. The digital state, the synchronized analog state and the combined state all appear as bits of a read-only status word. The same status word also accepts writes, and those writes have no effect.

Top module: `los_line_monitor`

## Requirements
- R1: A bit period holds a pulse when `rail_pos_i` or `rail_neg_i` (or both) is 1. Any single pulse restarts the run of pulse-free bit periods from zero.
- R2: The digital defect becomes 1 at the clock edge that samples the 160th consecutive pulse-free bit period. At that edge it does not yet hold after 159 such periods. The run count saturates at 160 and never wraps, so the defect stays declared through any longer silence.
- R3: Pulse density is measured over back-to-back windows of 96 bit periods. The first window starts at the first clock edge after reset. A declared defect clears at the edge that closes a window holding at least 32 pulses.
- R4: If a window closes with 31 or fewer pulses while the defect is declared, the defect stays declared. The next window begins at the very next bit period.
- R5: While reset is active and straight after it, the digital defect reads 1 and the synchronized analog state reads 0. The status word is then 8'h22.
- R6: `ana_los_async_i` reaches status bit 4 through two flops. A change on the input shows at status bit 4 after the second clock edge that samples it, and not after the first.
- R7: The channel loss state is the OR of the digital defect and the synchronized analog state. It appears on status bit 1 and on `los_o`.
- R8: `status_o` bit 5 is the digital defect, bit 4 the synchronized analog state and bit 1 the combined state. In each of these bits, 1 means a defect is declared. Bits 7, 6, 3, 2 and 0 read 0. Writes through `wr_en_i`/`wr_data_i` change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_pos_i | input | 1 | Positive-rail mark for this bit period |
| rail_neg_i | input | 1 | Negative-rail mark for this bit period |
| ana_los_async_i | input | 1 | Analog amplitude loss indication, asynchronous |
| wr_en_i | input | 1 | Status write strobe (ignored) |
| wr_data_i | input | 8 | Status write data (ignored) |
| status_o | output | 8 | Read-only status word |
| los_o | output | 1 | Combined channel loss state |

## Verification
On every cycle, the assertions check four things: a pulse restarts the run count, and the run count never passes its limit; a declare event leaves the defect set; the defect can fall only at the close of a passing window, and a failing window leaves it set; and the spare status bits stay zero while the combined bit implies one of its sources. Some properties only the bench's scenarios can show. These are the exact boundary counts (159 against 160 silent bits, 31 against 32 pulses), window phase relative to reset, the two-edge analog latency, and the fact that writes leave the status word unchanged. The bench shows them by comparing every cycle against a behavioural model and by making targeted checks at those edges.

// File: rtl/los_pkg.sv
package los_pkg;

  localparam int STAT_BIT_DIG = 5;
  localparam int STAT_BIT_ANA = 4;
  localparam int STAT_BIT_ALL = 1;

  // next value of a saturating up-counter
  function automatic int sat_next(input int cur, input int limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

  // pulse total for a window including the current bit
  function automatic int win_total(input int so_far, input logic pulse);
    return so_far + (pulse ? 1 : 0);
  endfunction

  function automatic logic density_met(input int total, input int min_pulses);
    return total >= min_pulses;
  endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int ZERO_RUN = 160,
  localparam int ZR_W = $clog2(ZERO_RUN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pulse_i,
  output logic [ZR_W-1:0] run_o,
  output logic            declare_o
);

  logic [ZR_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (pulse_i) begin
      run_q <= '0;
    end else begin
      run_q <= ZR_W'(los_pkg::sat_next(int'(run_q), ZERO_RUN));
    end
  end

  // this bit completes the required silent run
  assign declare_o = !pulse_i && (int'(run_q) == ZERO_RUN - 1);
  assign run_o     = run_q;

endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
  parameter int WIN_LEN = 96,
  parameter int WIN_MIN = 32,
  localparam int WC_W = $clog2(WIN_LEN),
  localparam int PC_W = $clog2(WIN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic win_end_o,
  output logic win_pass_o
);

  logic [WC_W-1:0] pos_q;
  logic [PC_W-1:0] cnt_q;
  int              total;

  always_comb begin
    total      = los_pkg::win_total(int'(cnt_q), pulse_i);
    win_end_o  = (int'(pos_q) == WIN_LEN - 1);
    win_pass_o = los_pkg::density_met(total, WIN_MIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (win_end_o) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
      cnt_q <= PC_W'(total);
    end
  end

endmodule

// File: rtl/los_sync.sv
module los_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/los_line_monitor.sv
module los_line_monitor #(
  parameter int ZERO_RUN    = 160,
  parameter int WIN_LEN     = 96,
  parameter int WIN_MIN     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 8,
  localparam int ZR_W = $clog2(ZERO_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rail_pos_i,
  input  logic              rail_neg_i,
  input  logic              ana_los_async_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              los_o
);

  logic            pulse;
  logic [ZR_W-1:0] zrun;
  logic            decl_evt;
  logic            win_end;
  logic            win_pass;
  logic            dig_q;
  logic            ana_sync;
  logic            unused_wr;

  assign pulse     = rail_pos_i | rail_neg_i;
  // status is read-only: write port is accepted and dropped
  assign unused_wr = wr_en_i ^ (^wr_data_i);

  los_zero_run #(.ZERO_RUN(ZERO_RUN)) u_zrun (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_i   (pulse),
    .run_o     (zrun),
    .declare_o (decl_evt)
  );

  los_density_win #(.WIN_LEN(WIN_LEN), .WIN_MIN(WIN_MIN)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_i    (pulse),
    .win_end_o  (win_end),
    .win_pass_o (win_pass)
  );

  los_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ana_los_async_i),
    .q_o   (ana_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_q <= 1'b1;
    end else if (decl_evt) begin
      dig_q <= 1'b1;
    end else if (win_end && win_pass) begin
      dig_q <= 1'b0;
    end
  end

  always_comb begin
    status_o                       = '0;
    status_o[los_pkg::STAT_BIT_DIG] = dig_q;
    status_o[los_pkg::STAT_BIT_ANA] = ana_sync;
    status_o[los_pkg::STAT_BIT_ALL] = dig_q | ana_sync;
    los_o                          = dig_q | ana_sync;
  end

endmodule

// File: rtl/los_line_monitor_chk.sv
module los_line_monitor_chk #(
  parameter int ZERO_RUN = 160,
  parameter int STAT_W   = 8,
  localparam int ZR_W = $clog2(ZERO_RUN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rail_pos_i,
  input logic              rail_neg_i,
  input logic [STAT_W-1:0] status_o,
  input logic              los_o,
  input logic [ZR_W-1:0]   zrun,
  input logic              decl_evt,
  input logic              win_end,
  input logic              win_pass
);

  AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_pos_i || rail_neg_i) |=> (zrun == '0)); // R1

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zrun) <= ZERO_RUN); // R2

  AST_DECLARE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    decl_evt |=> status_o[5]); // R2

  AST_CLEAR_ONLY_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[5]) |-> $past(win_end && win_pass)); // R3

  AST_SHORT_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !win_pass && status_o[5]) |=> status_o[5]); // R4

  AST_COMBINED_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    los_o |-> (status_o[5] || status_o[4])); // R7

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7:6] == 2'b00) && (status_o[3:2] == 2'b00) && !status_o[0]); // R8

endmodule

bind los_line_monitor los_line_monitor_chk #(.ZERO_RUN(ZERO_RUN), .STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rail_pos_i (rail_pos_i),
  .rail_neg_i (rail_neg_i),
  .status_o   (status_o),
  .los_o      (los_o),
  .zrun       (zrun),
  .decl_evt   (decl_evt),
  .win_end    (win_end),
  .win_pass   (win_pass)
);

// File: tb/tb_los_line_monitor.sv
`timescale 1ns/1ps
module tb_los_line_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pos = 1'b0, neg = 1'b0, ana = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status;
  logic       los;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  los_line_monitor dut (
    .clk(clk), .rst_n(rst_n), .rail_pos_i(pos), .rail_neg_i(neg),
    .ana_los_async_i(ana), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .status_o(status), .los_o(los)
  );

  // behavioural reference
  int   m_zeros, m_wpos, m_wcnt, m_dig;
  logic anaq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_zeros = 0; m_wpos = 0; m_wcnt = 0; m_dig = 1;
      anaq = '{1'b0, 1'b0};
    end else begin
      int p;
      p = (pos || neg) ? 1 : 0;
      if (p == 0 && m_zeros + 1 >= 160) m_dig = 1;
      else if (m_wpos == 95 && m_wcnt + p >= 32) m_dig = 0;
      m_zeros = p ? 0 : ((m_zeros < 160) ? m_zeros + 1 : 160);
      if (m_wpos == 95) begin m_wpos = 0; m_wcnt = 0; end
      else begin m_wpos++; m_wcnt += p; end
      anaq.push_back(ana);
      void'(anaq.pop_front());
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      e = (m_dig << 5) | (int'(anaq[0]) << 4) | ((m_dig | int'(anaq[0])) << 1);
      check("R8 model status", int'(status), e);
      check("R7 model los", int'(los), m_dig | int'(anaq[0]));
    end
  end

  task automatic tick(input logic p, input logic n);
    pos = p; neg = n;
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic zeros(input int k);
    for (int i = 0; i < k; i++) tick(1'b0, 1'b0);
  endtask

  // pulse on every third bit, alternating rails, for the first 'cnt' slots
  task automatic window(input int cnt);
    for (int i = 0; i < 96; i++) begin
      logic hit;
      hit = (i % 3 == 0) && (i / 3 < cnt);
      tick(hit && ((i / 3) % 2 == 0), hit && ((i / 3) % 2 == 1));
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset status", int'(status), 8'h22);
    rst_n = 1'b1;
    check("R5 released status", int'(status), 8'h22);

    // R3 / R1: first window after reset with 32 pulses on both rails
    for (int i = 0; i < 95; i++) tick((i % 6) == 0, (i % 6) == 3);
    check("R3 before window end", int'(status[5]), 1);
    tick(1'b0, 1'b0);
    check("R3 clear at window end", int'(status[5]), 0);

    window(32);
    tick(1'b0, 1'b1);
    zeros(150);
    tick(1'b1, 1'b0);
    zeros(159);
    check("R1 pulse restarted run", int'(status[5]), 0);
    zeros(1);
    check("R2 declare on 160th", int'(status[5]), 1);
    zeros(300);
    check("R2 saturated run holds", int'(status[5]), 1);

    while (cyc % 96 != 0) tick(1'b0, 1'b0);
    window(31);
    check("R4 31 pulses keep", int'(status[5]), 1);
    window(32);
    check("R4 next window clears", int'(status[5]), 0);

    // analog path with writes attempted
    ana = 1'b1; wr_en = 1'b1; wr_data = 8'hFF;
    tick(1'b1, 1'b0);
    check("R6 one edge not yet", int'(status[4]), 0);
    tick(1'b0, 1'b1);
    check("R6 two edges", int'(status[4]), 1);
    check("R7 combined", int'(los), 1);
    check("R8 writes ignored", int'(status), 8'h12);
    ana = 1'b0; wr_data = 8'h00;
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    check("R7 all clear", int'(status), 8'h00);
    check("R7 los clear", int'(los), 0);
    wr_en = 1'b0;

    ana = 1'b1;
    zeros(160);
    check("R7 both sources", int'(status), 8'h32);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule